// File: doc/BRIEF.md
# Packed Ternary Weight Unpacker

This block turns a stream of packed ternary weights into signed 8-bit values and stores them in one of two scratch tiles. Each input word holds 128 weights at two bits apiece, four weights to a byte. All 128 weights are decoded in the cycle the word is accepted, and the 128 result bytes are written as one row of a 4096-byte tile. A tile holds 32 rows, one 64x64 block of weights.

The two scratch tiles are used in ping-pong fashion. The producer side fills one half while a downstream multiply-accumulate engine reads the other half through a row-addressed read port. A filled tile is handed to the consumer only after all 32 of its rows have been written. The consumer gives a tile back with a one-cycle done pulse. If the consumer holds both halves, the input side stalls by dropping its ready signal. Any reserved code seen in the input sets a sticky error flag.

Top module: `ternary_unpack_top`

## Requirements
- R1: Each two-bit code decodes to a signed byte: code 00 gives 0x00, code 01 gives 0x01 (+1) and code 11 gives 0xFF (-1).
- R2: The reserved code 10 decodes to 0x00. An accepted word that contains it raises errFlag, which then stays high until reset.
- R3: Weight i of an input word comes from inWord bits [2i+1:2i], so within each byte the lowest weight sits in bits [1:0]. It appears in rdData bits [8i+7:8i]. The k-th accepted word of a tile is read back at rdAddr k.
- R4: tileAvail stays low while a tile has fewer than 32 accepted words. It rises in the cycle after the clock edge that accepts the 32nd word.
- R5: Tiles fill the halves alternately, starting with half 0. tileBuf names the half the consumer may read, and rdData always reads from that half.
- R6: When the consumer owns both halves, inReady is low. A word presented with inValid during that time is neither written nor counted.
- R7: A tileDone pulse while tileAvail is high frees the consumer's half and moves tileBuf to the other half. A tileDone pulse while tileAvail is low has no effect.
- R8: After reset, inReady is 1, tileAvail is 0, tileBuf is 0 and errFlag is 0.
- R9: Filling one half leaves the contents of the half the consumer is reading unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packed word present |
| inReady | output | 1 | A free half can take the word |
| inWord | input | 256 | 128 packed two-bit weights |
| tileDone | input | 1 | Consumer releases its current tile |
| rdAddr | input | 5 | Row index within the consumer's tile |
| tileAvail | output | 1 | A complete tile is owned by the consumer |
| tileBuf | output | 1 | Half the consumer reads |
| rdData | output | 1024 | 128 decoded signed bytes of the addressed row |
| errFlag | output | 1 | Sticky reserved-code indicator |

## Verification
A word accepted at a clock edge is in the scratch tile right after that edge. The read port has no register, so rdData answers the same cycle rdAddr changes. tileAvail, tileBuf, inReady and errFlag are registered and change one edge after the accepting handshake or the tileDone pulse. The bench drives inputs and samples outputs on the falling edge. It therefore checks every flag in the half-cycle after the rising edge that produces it, and reads data one time step after setting the address.

// File: rtl/tu_pkg.sv
package tu_pkg;
  localparam int ELEMS_PER_WORD = 128;
  localparam int CODE_W         = 2;
  localparam int OUT_W          = 8;
  localparam int ROWS_PER_TILE  = 32;
  localparam int HALVES         = 2;
  localparam int IN_W           = ELEMS_PER_WORD * CODE_W;
  localparam int ROW_W          = ELEMS_PER_WORD * OUT_W;
  localparam int IDX_W          = $clog2(ROWS_PER_TILE);
  localparam int DEPTH          = ROWS_PER_TILE * HALVES;

  typedef struct packed {
    logic             wrEn;
    logic             wrBuf;
    logic [IDX_W-1:0] wrIdx;
    logic             rdBuf;
  } strobes_t;
endpackage

// File: rtl/tu_datapath.sv
module tu_datapath
  import tu_pkg::*;
(
  input  logic             clk,
  input  strobes_t         strb,
  input  logic [IN_W-1:0]  inWord,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [ROW_W-1:0] rdData,
  output logic             badCode
);
  logic [ROW_W-1:0]          decRow;
  logic [ELEMS_PER_WORD-1:0] badVec;
  logic [ROW_W-1:0]          store [DEPTH];

  for (genvar i = 0; i < ELEMS_PER_WORD; i++) begin : g_dec
    logic [CODE_W-1:0] code;
    assign code = inWord[CODE_W*i +: CODE_W];
    always_comb begin
      badVec[i] = 1'b0;
      unique case (code)
        2'b01:   decRow[OUT_W*i +: OUT_W] = 8'h01;
        2'b11:   decRow[OUT_W*i +: OUT_W] = 8'hFF;
        2'b10: begin
          decRow[OUT_W*i +: OUT_W] = 8'h00;
          badVec[i] = 1'b1;
        end
        default: decRow[OUT_W*i +: OUT_W] = 8'h00;
      endcase
    end
  end

  assign badCode = |badVec;

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[{strb.wrBuf, strb.wrIdx}] <= decRow;
  end

  assign rdData = store[{strb.rdBuf, rdAddr}];
endmodule

// File: rtl/tu_control.sv
module tu_control
  import tu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        tileDone,
  input  logic        badCode,
  output strobes_t    strb,
  output logic        inReady,
  output logic        tileAvail,
  output logic        tileBuf,
  output logic        errFlag,
  output logic [1:0]  ownVec,
  output logic        fillLast
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROWS_PER_TILE - 1);

  logic [IDX_W-1:0] wrCnt;
  logic             wrPtr, rdPtr, errQ;
  logic [1:0]       fullQ;
  logic             accept, release_;

  assign inReady  = !fullQ[wrPtr];
  assign accept   = inValid && inReady;
  assign fillLast = accept && (wrCnt == LAST_IDX);
  assign release_ = tileDone && fullQ[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= '0;
      wrPtr <= 1'b0;
      rdPtr <= 1'b0;
      fullQ <= '0;
      errQ  <= 1'b0;
    end else begin
      if (accept) begin
        wrCnt <= fillLast ? '0 : wrCnt + 1'b1;
        if (badCode) errQ <= 1'b1;
      end
      if (fillLast) begin
        fullQ[wrPtr] <= 1'b1;
        wrPtr        <= !wrPtr;
      end
      if (release_) begin
        fullQ[rdPtr] <= 1'b0;
        rdPtr        <= !rdPtr;
      end
    end
  end

  always_comb begin
    strb.wrEn  = accept;
    strb.wrBuf = wrPtr;
    strb.wrIdx = wrCnt;
    strb.rdBuf = rdPtr;
  end

  assign tileAvail = fullQ[rdPtr];
  assign tileBuf   = rdPtr;
  assign errFlag   = errQ;
  assign ownVec    = fullQ;
endmodule

// File: rtl/ternary_unpack_top.sv
module ternary_unpack_top
  import tu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [IN_W-1:0]  inWord,
  input  logic             tileDone,
  input  logic [IDX_W-1:0] rdAddr,
  output logic             tileAvail,
  output logic             tileBuf,
  output logic [ROW_W-1:0] rdData,
  output logic             errFlag
);
  strobes_t   strb;
  logic       badCode;
  logic [1:0] ownVec;
  logic       fillLast;

  tu_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tileDone(tileDone),
    .badCode(badCode), .strb(strb), .inReady(inReady),
    .tileAvail(tileAvail), .tileBuf(tileBuf), .errFlag(errFlag),
    .ownVec(ownVec), .fillLast(fillLast)
  );

  tu_datapath u_dp (
    .clk(clk), .strb(strb), .inWord(inWord), .rdAddr(rdAddr),
    .rdData(rdData), .badCode(badCode)
  );
endmodule

// File: rtl/tu_check.sv
module tu_check (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       tileDone,
  input logic       tileAvail,
  input logic       tileBuf,
  input logic       errFlag,
  input logic [1:0] ownVec,
  input logic       fillLast
);
  // R4
  avail_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tileAvail) |-> $past(fillLast));
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ownVec == 2'b11) |-> !inReady);
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tileDone && tileAvail) |=> (tileBuf != $past(tileBuf)));
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R5
  fill_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLast |=> ($countones(ownVec) >= 1));
endmodule

bind ternary_unpack_top tu_check u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .tileDone(tileDone),
  .tileAvail(tileAvail), .tileBuf(tileBuf), .errFlag(errFlag),
  .ownVec(ownVec), .fillLast(fillLast)
);

// File: tb/sim_ternary_unpack_top.sv
`timescale 1ns/1ps
module sim_ternary_unpack_top;
  import tu_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [IN_W-1:0]  inWord = '0;
  logic             tileDone = 1'b0;
  logic [IDX_W-1:0] rdAddr = '0;
  logic             tileAvail, tileBuf, errFlag;
  logic [ROW_W-1:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = !clk;

  ternary_unpack_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .tileDone(tileDone), .rdAddr(rdAddr),
    .tileAvail(tileAvail), .tileBuf(tileBuf), .rdData(rdData),
    .errFlag(errFlag)
  );

  // {packed byte, expected four decoded bytes, weight 3 in the top byte}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 32'h00000000},
    {8'h55, 32'h01010101},
    {8'hFF, 32'hFFFFFFFF},
    {8'h1D, 32'h0001FF01},
    {8'hC4, 32'hFF000100},
    {8'h37, 32'h00FF01FF},
    {8'h71, 32'h01FF0001},
    {8'hD3, 32'hFF0100FF}
  };

  function automatic logic [IN_W-1:0] packWord(int k, int off);
    logic [IN_W-1:0] w;
    for (int b = 0; b < IN_W/8; b++) w[8*b +: 8] = VEC[(k+off+b)%8][39:32];
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] expRow(int k, int off);
    logic [ROW_W-1:0] r;
    for (int b = 0; b < IN_W/8; b++) r[32*b +: 32] = VEC[(k+off+b)%8][31:0];
    return r;
  endfunction

  task automatic chkBit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chkRow(string req, int addr, logic [ROW_W-1:0] exp);
    @(negedge clk);
    rdAddr = IDX_W'(addr);
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s row %0d: actual=%h expected=%h", req, addr, rdData, exp);
    end
  endtask

  task automatic sendWord(logic [IN_W-1:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    tileDone = 1'b1;
    @(posedge clk);
    #1 tileDone = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R8 reset state
    chkBit("R8", "inReady", inReady, 1'b1);
    chkBit("R8", "tileAvail", tileAvail, 1'b0);
    chkBit("R8", "tileBuf", tileBuf, 1'b0);
    chkBit("R8", "errFlag", errFlag, 1'b0);

    // Table walk: tile A into half 0, every row mixing the vectors
    for (int k = 0; k < ROWS_PER_TILE; k++) begin
      sendWord(packWord(k, 0));
      @(negedge clk);
      if (k == ROWS_PER_TILE - 2) chkBit("R4", "avail before 32nd word", tileAvail, 1'b0);
    end
    chkBit("R4", "avail after 32nd word", tileAvail, 1'b1);
    chkBit("R5", "first tile in half 0", tileBuf, 1'b0);
    chkBit("R2", "no error on legal codes", errFlag, 1'b0);
    for (int k = 0; k < ROWS_PER_TILE; k++) chkRow("R1 R3", k, expRow(k, 0));

    // Tile B into half 1 while half 0 is read
    for (int k = 0; k < ROWS_PER_TILE; k++) begin
      sendWord(packWord(k, 3));
      if (k == 10) chkRow("R9", 5, expRow(5, 0));
    end
    @(negedge clk);
    chkBit("R6", "inReady with both halves owned", inReady, 1'b0);

    // Stalled stimulus must be dropped
    @(negedge clk);
    inValid = 1'b1;
    inWord  = {(IN_W/8){8'hFF}};
    repeat (3) @(posedge clk);
    #1 inValid = 1'b0;
    chkBit("R6", "tileBuf stable during stall", tileBuf, 1'b0);
    chkRow("R6", 0, expRow(0, 0));

    // Release half 0
    pulseDone();
    @(negedge clk);
    chkBit("R7", "tileBuf after release", tileBuf, 1'b1);
    chkBit("R7", "tileAvail with half 1 full", tileAvail, 1'b1);
    chkBit("R6", "inReady after release", inReady, 1'b1);
    for (int k = 0; k < ROWS_PER_TILE; k += 7) chkRow("R5 R6", k, expRow(k, 3));

    pulseDone();
    @(negedge clk);
    chkBit("R7", "tileAvail after second release", tileAvail, 1'b0);
    chkBit("R7", "tileBuf after second release", tileBuf, 1'b0);
    pulseDone();
    @(negedge clk);
    chkBit("R7", "tileBuf unchanged by done without tile", tileBuf, 1'b0);
    chkBit("R7", "tileAvail unchanged by done without tile", tileAvail, 1'b0);

    // Reserved code in the first row of a tile
    sendWord({(IN_W/8){8'hAA}});
    @(negedge clk);
    chkBit("R2", "errFlag after reserved code", errFlag, 1'b1);
    for (int k = 1; k < ROWS_PER_TILE; k++) sendWord({(IN_W/8){8'h55}});
    @(negedge clk);
    chkBit("R2", "errFlag sticky", errFlag, 1'b1);
    chkBit("R4", "avail for error tile", tileAvail, 1'b1);
    chkRow("R2", 0, '0);
    chkRow("R1", 1, {(ROW_W/8){8'h01}});

    doReset();
    chkBit("R8", "errFlag after reset", errFlag, 1'b0);
    chkBit("R8", "tileAvail after reset", tileAvail, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule